// File: doc/BRIEF.md
# Power-Down Reset and Fade Sequencer

This block sequences the power-down and restart of a stereo converter core's two data paths, capture and playback, each controlled by its own active-low enable pin. It produces one internal core reset, a flag that forces captured samples to zero, and a playback gain word that is also applied to the playback sample stream. The aim is click-free muting: playback volume ramps linearly rather than stepping.

The core reset is held while both paths are disabled. When either path is enabled, the reset is released only after a fixed number of system clocks has elapsed. After release, the capture path keeps its output at zero for a programmable number of frame periods. The playback gain climbs one step per frame tick until it reaches unity. When playback is disabled, the gain ramps back down to zero, starting from wherever it currently is.

Top module: `pd_fade_seq`

## Requirements
- R1: The core reset output is low (asserted) during `rst_n` reset and whenever both synchronized enables are low and the playback gain is zero; while the core reset is low the gain is zero.
- R2: Each enable passes through a two-flop synchronizer. Once either enable is sampled high, the core reset stays low for exactly RELEASE_CLKS further clocks, so it rises on the (RELEASE_CLKS+2)th clock edge. If both enables drop during the count, the count restarts.
- R3: `cap_zero` is high while the core is in reset. After the core is out of reset and the capture enable is high, it stays high for CAP_INIT_FRAMES frame ticks and then goes low. Each re-enable repeats this wait.
- R4: Dropping the capture enable sets `cap_zero` high on the edge after the synchronized value falls, and leaves the playback gain unchanged.
- R5: The playback gain is floor(k * 2^(GAIN_W-1) / FADE_FRAMES), where the step count k runs from 0 to FADE_FRAMES. k rises by one on each frame tick while playback is enabled and the core is out of reset, so the gain reaches unity (2^(GAIN_W-1)) after FADE_FRAMES ticks.
- R6: Dropping the playback enable lowers k by one on each frame tick until k reaches zero, so a fade-out from unity takes FADE_FRAMES ticks. The capture flag is unaffected.
- R7: A direction change in mid-ramp continues from the current step. A power-down during a fade-in ramps down from the gain already reached, and a re-enable during a fade-out ramps up from the current gain.
- R8: `play_out` is registered one clock after its inputs. It equals (signed `play_in` × gain) arithmetically shifted right by GAIN_W-1, so it is zero (mid-scale) whenever the gain is zero.
- R9: When both enables are low but the playback gain is not yet zero, the core reset stays released until the fade-out completes.
- R10: The gain changes only on clocks where `frame_tick` is high. Between ticks it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| frame_tick | input | 1 | One-clock pulse per sample period |
| cap_pd_n | input | 1 | Capture path enable, low = powered down (asynchronous) |
| play_pd_n | input | 1 | Playback path enable, low = powered down (asynchronous) |
| play_in | input | SAMPLE_W | Signed playback sample |
| core_rst_n | output | 1 | Internal core reset, active low |
| cap_zero | output | 1 | High = force capture samples to zero |
| play_gain | output | GAIN_W | Unsigned playback gain, unity = 2^(GAIN_W-1) |
| play_out | output | SAMPLE_W | Gain-scaled signed playback sample |

## Verification
The bench measures the release delay edge by edge. A counter that is one clock short or one clock long, or a missing synchronizer stage, therefore shows up as an early or late `core_rst_n` rise. It drops playback partway through a fade-in and re-enables it partway through a fade-out. A design that reloads unity, or restarts from zero, would jump the gain instead of stepping it. It powers down both paths while the gain is still at unity. A design that asserts the core reset immediately would cut the fade short, and the core reset would fall while the gain is still nonzero. It also holds the frame tick off, so that a ramp clocked by the system clock would reveal itself. It feeds full-scale negative samples, which catch an unsigned multiply or a logical shift.

// File: rtl/pdfs_pkg.sv
// Shared types for the power-down sequencer.
package pdfs_pkg;

    // Capture path state: powered off, settling, delivering data.
    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_INIT = 2'd1,
        CAP_RUN  = 2'd2
    } cap_state_t;

    // Width for a counter that must hold 0..n-1, never below one bit.
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pdfs_rst_ctl.sv
// Core reset generator.
// Holds the core reset while no path is enabled and playback is silent.
// Releases it RELEASE_CLKS clocks after any enable is seen.
// Assumes any_en is already synchronized to clk.
module pdfs_rst_ctl #(
    parameter int RELEASE_CLKS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_en,
    input  logic play_idle,
    output logic core_rst_n
);
    localparam int CW = pdfs_pkg::cnt_width(RELEASE_CLKS);
    localparam logic [CW-1:0] LAST = CW'(RELEASE_CLKS - 1);

    logic [CW-1:0] rel_cnt;
    logic          hold;

    assign hold = !any_en && play_idle;

    // Purpose: hold reset while requested, else count out the release delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_cnt    <= '0;
            core_rst_n <= 1'b0;
        end else if (hold) begin
            rel_cnt    <= '0;
            core_rst_n <= 1'b0;
        end else if (!core_rst_n) begin
            if (rel_cnt == LAST) begin
                core_rst_n <= 1'b1;
            end else begin
                rel_cnt <= rel_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pdfs_cap_gate.sv
// Capture output gate.
// Forces capture samples to zero while the capture path is powered down or the core is in reset.
// After enable, also forces zero for CAP_INIT_FRAMES frame ticks.
// Assumes cap_en is synchronized and frame_tick is a one-clock pulse.
module pdfs_cap_gate
    import pdfs_pkg::*;
#(
    parameter int CAP_INIT_FRAMES = 2240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_rst_n,
    input  logic cap_en,
    input  logic frame_tick,
    output logic cap_zero
);
    localparam int FW = cnt_width(CAP_INIT_FRAMES);
    localparam logic [FW-1:0] LAST = FW'(CAP_INIT_FRAMES - 1);

    cap_state_t    state;
    logic [FW-1:0] frm_cnt;

    // Purpose: step the capture path through off, settle and run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= CAP_OFF;
            frm_cnt <= '0;
        end else if (!core_rst_n || !cap_en) begin
            state   <= CAP_OFF;
            frm_cnt <= '0;
        end else begin
            case (state)
                CAP_OFF: begin
                    state   <= CAP_INIT;
                    frm_cnt <= '0;
                end
                CAP_INIT: begin
                    if (frame_tick) begin
                        if (frm_cnt == LAST) state <= CAP_RUN;
                        else                 frm_cnt <= frm_cnt + 1'b1;
                    end
                end
                default: state <= CAP_RUN;
            endcase
        end
    end

    // Purpose: zero-force flag is active everywhere except the run state.
    assign cap_zero = (state != CAP_RUN);
endmodule

// File: rtl/pdfs_gain_ramp.sv
// Linear playback gain ramp.
// The step count k moves by one per frame tick, toward FADE_FRAMES when ramp_up is high and toward zero otherwise.
// The gain is floor(k*UNITY/FADE_FRAMES), tracked incrementally with a quotient and remainder so that no divider is needed.
// Assumes UNITY >= FADE_FRAMES, so every step changes the gain.
module pdfs_gain_ramp #(
    parameter int FADE_FRAMES = 2080,
    parameter int GAIN_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              ramp_up,
    output logic [GAIN_W-1:0] gain,
    output logic              idle
);
    localparam int UNITY = 1 << (GAIN_W - 1);
    localparam int QUO   = UNITY / FADE_FRAMES;
    localparam int REM   = UNITY % FADE_FRAMES;
    localparam int KW    = $clog2(FADE_FRAMES + 1);
    localparam int RW    = $clog2(FADE_FRAMES) + 1;
    localparam logic [KW-1:0]     K_TOP   = KW'(FADE_FRAMES);
    localparam logic [RW:0]       DEN     = (RW+1)'(FADE_FRAMES);
    localparam logic [RW:0]       REM_INC = (RW+1)'(REM);
    localparam logic [GAIN_W-1:0] QUO_G   = GAIN_W'(QUO);

    logic [KW-1:0]     k_q;
    logic [RW-1:0]     rem_q;
    logic [GAIN_W-1:0] gain_q;
    logic              step_up, step_dn;
    logic [RW:0]       sum_up, rem_ext;
    logic              carry, borrow;

    assign step_up = frame_tick && ramp_up  && (k_q != K_TOP);
    assign step_dn = frame_tick && !ramp_up && (k_q != '0);

    // Purpose: remainder arithmetic for one step in either direction.
    always_comb begin
        rem_ext = {1'b0, rem_q};
        sum_up  = rem_ext + REM_INC;
        carry   = (sum_up >= DEN);
        borrow  = (rem_ext < REM_INC);
    end

    // Purpose: advance step count, remainder and gain together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_q    <= '0;
            rem_q  <= '0;
            gain_q <= '0;
        end else if (step_up) begin
            k_q    <= k_q + 1'b1;
            rem_q  <= RW'(carry ? sum_up - DEN : sum_up);
            gain_q <= gain_q + QUO_G + GAIN_W'(carry);
        end else if (step_dn) begin
            k_q    <= k_q - 1'b1;
            rem_q  <= RW'(borrow ? rem_ext + DEN - REM_INC : rem_ext - REM_INC);
            gain_q <= gain_q - QUO_G - GAIN_W'(borrow);
        end
    end

    assign gain = gain_q;
    assign idle = (k_q == '0);
endmodule

// File: rtl/pdfs_gain_apply.sv
// Playback sample scaler.
// Multiplies the signed sample by the unsigned gain and drops GAIN_W-1 fraction bits with an arithmetic shift.
// The result is registered.
// Assumes gain never exceeds unity, so the result fits SAMPLE_W bits.
module pdfs_gain_apply #(
    parameter int SAMPLE_W = 16,
    parameter int GAIN_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic        [GAIN_W-1:0]   gain,
    output logic signed [SAMPLE_W-1:0] sample_out
);
    localparam int PW = SAMPLE_W + GAIN_W + 1;

    logic signed [PW-1:0] prod;

    // Purpose: full-precision signed product.
    always_comb begin
        prod = sample_in * $signed({1'b0, gain});
    end

    // Purpose: register the scaled sample.
    always_ff @(posedge clk) begin
        if (!rst_n) sample_out <= '0;
        else        sample_out <= SAMPLE_W'(prod >>> (GAIN_W - 1));
    end
endmodule

// File: rtl/pd_fade_seq.sv
// Power-down reset and fade sequencer, top level.
// Synchronizes the two path enables, generates the core reset, gates the capture output and ramps the playback gain.
// The enables may change asynchronously; everything else is synchronous to clk.
module pd_fade_seq #(
    parameter int RELEASE_CLKS    = 1024,
    parameter int CAP_INIT_FRAMES = 2240,
    parameter int FADE_FRAMES     = 2080,
    parameter int GAIN_W          = 16,
    parameter int SAMPLE_W        = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_tick,
    input  logic                       cap_pd_n,
    input  logic                       play_pd_n,
    input  logic signed [SAMPLE_W-1:0] play_in,
    output logic                       core_rst_n,
    output logic                       cap_zero,
    output logic        [GAIN_W-1:0]   play_gain,
    output logic signed [SAMPLE_W-1:0] play_out
);
    localparam int NPATH = 2;

    logic [NPATH-1:0] pd_raw, meta_q, sync_q;
    logic             cap_en_s, play_en_s, play_idle;

    assign pd_raw = {play_pd_n, cap_pd_n};

    genvar gi;
    generate
        for (gi = 0; gi < NPATH; gi++) begin : g_sync
            // Purpose: two-flop synchronizer for one enable.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q[gi] <= 1'b0;
                    sync_q[gi] <= 1'b0;
                end else begin
                    meta_q[gi] <= pd_raw[gi];
                    sync_q[gi] <= meta_q[gi];
                end
            end
        end
    endgenerate

    assign cap_en_s  = sync_q[0];
    assign play_en_s = sync_q[1];

    pdfs_rst_ctl #(.RELEASE_CLKS(RELEASE_CLKS)) u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_en     (cap_en_s | play_en_s),
        .play_idle  (play_idle),
        .core_rst_n (core_rst_n)
    );

    pdfs_cap_gate #(.CAP_INIT_FRAMES(CAP_INIT_FRAMES)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_rst_n (core_rst_n),
        .cap_en     (cap_en_s),
        .frame_tick (frame_tick),
        .cap_zero   (cap_zero)
    );

    pdfs_gain_ramp #(.FADE_FRAMES(FADE_FRAMES), .GAIN_W(GAIN_W)) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .ramp_up    (core_rst_n & play_en_s),
        .gain       (play_gain),
        .idle       (play_idle)
    );

    pdfs_gain_apply #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_apply (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_in  (play_in),
        .gain       (play_gain),
        .sample_out (play_out)
    );
endmodule

// File: rtl/pd_fade_seq_chk.sv
// Property checker for pd_fade_seq, attached with bind.
// Observes the ports and the synchronized enables.
module pd_fade_seq_chk #(
    parameter int GAIN_W   = 16,
    parameter int SAMPLE_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       frame_tick,
    input logic                       cap_en_s,
    input logic                       play_en_s,
    input logic                       core_rst_n,
    input logic                       cap_zero,
    input logic        [GAIN_W-1:0]   play_gain,
    input logic signed [SAMPLE_W-1:0] play_out
);
    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << (GAIN_W - 1));

    // R1
    core_rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en_s && !play_en_s && play_gain == '0) |=> !core_rst_n);

    // R1
    rst_gain_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_n |-> (play_gain == '0));

    // R3
    rst_cap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_n |-> cap_zero);

    // R4
    cap_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_s |=> cap_zero);

    // R5
    gain_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        play_gain <= UNITY);

    // R10
    gain_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (play_gain != $past(play_gain)) |-> $past(frame_tick));

    // R8
    mute_midscale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (play_gain == '0) |=> (play_out == '0));
endmodule

bind pd_fade_seq pd_fade_seq_chk #(.GAIN_W(GAIN_W), .SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/sim_pd_fade_seq.sv
module sim_pd_fade_seq;
    localparam int REL   = 16;
    localparam int CINIT = 10;
    localparam int FADE  = 6;
    localparam int GW    = 16;
    localparam int SW    = 16;
    localparam int UNITY = 1 << (GW - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_tick = 1'b0;
    logic cap_pd_n = 1'b0;
    logic play_pd_n = 1'b0;
    logic signed [SW-1:0] play_in = '0;
    logic core_rst_n, cap_zero;
    logic [GW-1:0] play_gain;
    logic signed [SW-1:0] play_out;

    always #5 clk = ~clk;

    pd_fade_seq #(.RELEASE_CLKS(REL), .CAP_INIT_FRAMES(CINIT), .FADE_FRAMES(FADE),
                  .GAIN_W(GW), .SAMPLE_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .cap_pd_n(cap_pd_n),
        .play_pd_n(play_pd_n), .play_in(play_in), .core_rst_n(core_rst_n),
        .cap_zero(cap_zero), .play_gain(play_gain), .play_out(play_out));

    int vectors = 0;
    int misses  = 0;
    bit tick_on = 1'b1;
    int tick_div = 0;
    bit done = 1'b0;

    function automatic int gain_of(input int k);
        return (k * UNITY) / FADE;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_ok(input string tag, input bit ok, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual=%0d expected bound=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: synchronizer delay, release count, frame counts, step count.
    int ms1c, ms2c, ms1p, ms2p, mcore, mrc, mcst, mccnt, mk, mout;
    initial begin
        ms1c = 0; ms2c = 0; ms1p = 0; ms2p = 0; mcore = 0; mrc = 0;
        mcst = 0; mccnt = 0; mk = 0; mout = 0;
    end

    always @(posedge clk) begin
        int nk, s;
        bit any, up;
        if (!rst_n) begin
            ms1c = 0; ms2c = 0; ms1p = 0; ms2p = 0; mcore = 0; mrc = 0;
            mcst = 0; mccnt = 0; mk = 0; mout = 0;
        end else begin
            any = (ms2c != 0) || (ms2p != 0);
            // capture: 0 off, 1 settling, 2 running
            if (mcore == 0 || ms2c == 0) begin
                mcst = 0; mccnt = 0;
            end else if (mcst == 0) begin
                mcst = 1; mccnt = 0;
            end else if (mcst == 1 && frame_tick) begin
                if (mccnt == CINIT - 1) mcst = 2;
                else mccnt++;
            end
            up = (mcore != 0) && (ms2p != 0);
            nk = mk;
            if (frame_tick) begin
                if (up && mk < FADE) nk = mk + 1;
                else if (!up && mk > 0) nk = mk - 1;
            end
            if (!any && mk == 0) begin
                mcore = 0; mrc = 0;
            end else if (mcore == 0) begin
                if (mrc == REL - 1) mcore = 1;
                else mrc++;
            end
            s = play_in;
            mout = (s * gain_of(mk)) >>> (GW - 1);
            mk = nk;
            ms2c = ms1c; ms1c = cap_pd_n;
            ms2p = ms1p; ms1p = play_pd_n;
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk("R2 core_rst_n", core_rst_n, mcore);
            chk("R3 cap_zero", cap_zero, (mcst != 2) ? 1 : 0);
            chk("R5 play_gain", play_gain, gain_of(mk));
            chk("R8 play_out", $signed(play_out), mout);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            tick_div = (tick_div + 1) % 4;
            frame_tick = tick_on && (tick_div == 0);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        misses++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int n, gd, gmax;
        step(4);
        // R1: reset state
        chk("R1 reset core_rst_n", core_rst_n, 0);
        chk("R3 reset cap_zero", cap_zero, 1);
        chk("R1 reset gain", play_gain, 0);
        chk("R8 reset out", play_out, 0);
        rst_n = 1'b1;
        step(3);
        chk("R1 both low", core_rst_n, 0);

        // R2: release delay measured in clocks
        play_pd_n = 1'b1;
        n = 0;
        while (!core_rst_n && n < 100) begin step(1); n++; end
        chk("R2 release clocks", n, REL + 2);

        // R5: fade-in reaches unity
        step(FADE * 4 + 8);
        chk("R5 unity", play_gain, UNITY);

        // R8: scaling at unity, including full-scale negative
        play_in = 16'sd12345; step(2);
        chk("R8 pass positive", $signed(play_out), 12345);
        play_in = -16'sd32768; step(2);
        chk("R8 pass negative", $signed(play_out), -32768);

        // R3: capture settle time
        cap_pd_n = 1'b1;
        step(8);
        chk("R3 still settling", cap_zero, 1);
        step(CINIT * 4 + 8);
        chk("R3 settled", cap_zero, 0);

        // R4: capture power-down does not disturb playback
        cap_pd_n = 1'b0;
        step(3);
        chk("R4 cap forced zero", cap_zero, 1);
        chk("R4 gain untouched", play_gain, UNITY);
        chk("R4 core stays up", core_rst_n, 1);
        cap_pd_n = 1'b1;
        step(8);
        chk("R3 re-settle", cap_zero, 1);
        step(CINIT * 4 + 8);
        chk("R3 re-settled", cap_zero, 0);

        // R6: playback fade-out with capture running
        play_in = 16'sd20000;
        play_pd_n = 1'b0;
        step(6);
        chk_ok("R6 fading", play_gain > 0 && play_gain < UNITY, play_gain, UNITY);
        step(FADE * 4 + 8);
        chk("R6 faded", play_gain, 0);
        chk("R8 midscale", play_out, 0);
        chk("R6 capture unaffected", cap_zero, 0);
        chk("R6 core stays up", core_rst_n, 1);

        // R7: reversal during fade-in
        play_pd_n = 1'b1;
        n = 0;
        while (play_gain < gain_of(3) && n < 100) begin step(1); n++; end
        play_pd_n = 1'b0;
        gd = play_gain;
        gmax = gd;
        for (int i = 0; i < 30; i++) begin
            step(1);
            if (play_gain > gmax) gmax = play_gain;
        end
        chk_ok("R7 no jump to unity", gmax <= gain_of(4), gmax, gain_of(4));
        chk("R7 back to zero", play_gain, 0);

        // R7: reversal during fade-out
        play_pd_n = 1'b1;
        step(FADE * 4 + 8);
        play_pd_n = 1'b0;
        step(10);
        gd = play_gain;
        play_pd_n = 1'b1;
        step(3);
        chk_ok("R7 resumes from current", play_gain >= gd - gain_of(1) && play_gain < UNITY,
               play_gain, gd);

        // R9: both off while at unity waits for the fade-out
        step(FADE * 4 + 8);
        cap_pd_n = 1'b0;
        play_pd_n = 1'b0;
        step(6);
        chk("R9 reset waits", core_rst_n, 1);
        chk_ok("R9 still fading", play_gain > 0, play_gain, 1);
        step(FADE * 4 + 10);
        chk("R1 reset after fade", core_rst_n, 0);

        // R2: dropping both during the count restarts it
        play_pd_n = 1'b1;
        step(8);
        play_pd_n = 1'b0;
        step(REL + 4);
        chk("R2 aborted release", core_rst_n, 0);

        // R10: no ticks, no ramp
        tick_on = 1'b0;
        play_pd_n = 1'b1;
        step(REL + 20);
        chk("R2 released", core_rst_n, 1);
        chk("R10 held without ticks", play_gain, 0);
        tick_on = 1'b1;
        step(12);
        chk_ok("R5 ramps with ticks", play_gain > 0, play_gain, 1);
        step(FADE * 4 + 4);
        chk("R5 unity again", play_gain, UNITY);

        finish_run();
    end
endmodule